// File: doc/BRIEF.md
# Table-Driven Binary to Packed-BCD Converter

This block turns an unsigned binary word into packed BCD. A start pulse captures the word and clears a decimal accumulator. The block then walks the input bits from the most significant one down to bit 0, one bit per clock. For every bit that is set, it fetches the decimal value of the matching power of two from a constant table. It adds that value into the accumulator through a decimal adder whose carries are resolved per digit with generate and propagate terms.

The width is fixed when the block is built. `DATA_W` is 16 or 32, and there is no run-time mode switch. From that width the block derives its other sizes:

- the digit count, `(DATA_W+8)/4`, which is 6 or 10;
- the table depth, `DATA_W` entries;
- the step counter's load value, `DATA_W-1`;
- the result port width, `2*DATA_W` bits, which reads as 8 or 16 BCD digits.

A client raises `start` for one cycle while the block is idle. It then waits for the one-cycle `done` pulse and reads `bcd_out`, which keeps its value until the next accepted start.

Top module: `bcd_table_conv`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy` and `done` are 0 and `bcd_out` is all zero.
- R2: A `start` sampled high while `busy` is low captures `din`. In the following cycle `busy` is 1 and `bcd_out` is all zero.
- R3: `done` is high for exactly one cycle, after the `DATA_W+1`-th rising edge that follows the edge which accepted `start`. `busy` is already low in that cycle.
- R4: When `done` is high, `bcd_out` holds the decimal value of the captured word as packed BCD: decimal digit i (units at i=0) sits in bits [4i+3:4i]. All digits above the first `(DATA_W+8)/4` are zero. A scan step for a clear input bit leaves the accumulator unchanged.
- R5: Every 4-bit group of `bcd_out` holds a value from 0 to 9 in every cycle.
- R6: While `busy` is low and no start is accepted, `bcd_out` does not change.
- R7: A `start` pulse while `busy` is high is ignored. The running conversion finishes with the originally captured word and on the original schedule.
- R8: An input of 0 gives an all-zero result. An all-ones input gives 65535 for a 16-bit build and 4294967295 for a 32-bit build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to convert `din`; honoured only when idle |
| din | input | DATA_W | Unsigned binary word to convert |
| busy | output | 1 | High while a conversion is in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| bcd_out | output | 2*DATA_W | Packed BCD result, units digit in bits [3:0] |

## Verification
The assertions check on every cycle the properties that need no arithmetic reference:

- every nibble of the accumulator stays a valid decimal digit;
- the result is cleared when a start is accepted;
- the result is held while idle;
- `done` is a single pulse, and `busy` falls only when `done` rises;
- a clear input bit adds nothing;
- a start during a conversion leaves the captured word untouched.

Only the bench's scenarios can show that the final digits equal the decimal value of the input and that the done pulse arrives after exactly `DATA_W+1` edges. The bench covers this with a full sweep of small 16-bit values, a strided sweep of the rest of the 16-bit range, pseudo-random 32-bit words, both extreme inputs, and starts injected in the middle of a conversion.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  // Decimal digits of 2**k, packed BCD, up to 20 digits (enough for k <= 63).
  function automatic logic [79:0] pow2_bcd(input int k);
    logic [79:0] val;
    int          carry;
    int          t;
    val = 80'd1;
    for (int s = 0; s < k; s++) begin
      carry = 0;
      for (int d = 0; d < 20; d++) begin
        t = 2 * int'(val[4*d +: 4]) + carry;
        if (t >= 10) begin
          t     = t - 10;
          carry = 1;
        end else begin
          carry = 0;
        end
        val[4*d +: 4] = 4'(t);
      end
    end
    return val;
  endfunction

  // True when the lowest n nibbles of v are all legal decimal digits.
  function automatic bit digits_ok(input logic [127:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    end
    return 1'b1;
  endfunction

endpackage

// File: rtl/bcd_pow2_rom.sv
module bcd_pow2_rom
  import bcd_conv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIGITS = (DATA_W + 8) / 4
) (
  input  logic                      clk,
  input  logic [$clog2(DATA_W)-1:0] addr,
  output logic [4*DIGITS-1:0]       q
);
  localparam int BCD_W = 4 * DIGITS;

  logic [BCD_W-1:0] rom_tbl [DATA_W];

  for (genvar k = 0; k < DATA_W; k++) begin : g_entry
    localparam logic [79:0] ENTRY = pow2_bcd(k);
    assign rom_tbl[k] = ENTRY[BCD_W-1:0];
  end

  // Registered read so the constant table can map onto a block ROM.
  always_ff @(posedge clk) begin
    q <= rom_tbl[addr];
  end

endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder #(
  parameter int DIGITS = 10
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  output logic [4*DIGITS-1:0] sum
);
  logic [DIGITS-1:0] gen;
  logic [DIGITS-1:0] prop;
  logic [DIGITS-1:0] cin;

  assign cin[0] = 1'b0;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] tot;
    logic [4:0] adj;

    assign raw       = {1'b0, a[4*gi +: 4]} + {1'b0, b[4*gi +: 4]};
    // Per-digit carry terms: generate when the pair reaches ten,
    // propagate when it is exactly nine.
    assign gen[gi]   = (raw > 5'd9);
    assign prop[gi]  = (raw == 5'd9);
    assign tot       = raw + {4'd0, cin[gi]};
    assign adj       = tot - 5'd10;
    assign sum[4*gi +: 4] = (tot > 5'd9) ? adj[3:0] : tot[3:0];

    if (gi < DIGITS - 1) begin : g_carry
      assign cin[gi+1] = gen[gi] | (prop[gi] & cin[gi]);
    end
  end

endmodule

// File: rtl/bcd_table_conv.sv
module bcd_table_conv
  import bcd_conv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [DATA_W-1:0]   din,
  output logic                busy,
  output logic                done,
  output logic [2*DATA_W-1:0] bcd_out
);
  localparam int DIGITS = (DATA_W + 8) / 4;
  localparam int BCD_W  = 4 * DIGITS;
  localparam int ACC_W  = 2 * DATA_W;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] src;
  logic [CNT_W-1:0]  cnt;
  logic              issuing;
  logic              stg_v;
  logic              bit_q;
  logic              last_q;
  logic [BCD_W-1:0]  acc;
  logic [BCD_W-1:0]  entry;
  logic [BCD_W-1:0]  acc_sum;

  bcd_pow2_rom #(
    .DATA_W (DATA_W),
    .DIGITS (DIGITS)
  ) u_rom (
    .clk  (clk),
    .addr (cnt),
    .q    (entry)
  );

  bcd_digit_adder #(
    .DIGITS (DIGITS)
  ) u_add (
    .a   (acc),
    .b   (entry),
    .sum (acc_sum)
  );

  // Scan stage: reads the table entry for bit cnt and records that bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      src     <= '0;
      cnt     <= '0;
      issuing <= 1'b0;
      stg_v   <= 1'b0;
      bit_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (start && !busy) begin
        src     <= din;
        cnt     <= CNT_TOP;
        issuing <= 1'b1;
      end else if (issuing) begin
        if (cnt == '0) issuing <= 1'b0;
        else           cnt     <= cnt - 1'b1;
      end
      stg_v  <= issuing;
      bit_q  <= issuing & src[cnt];
      last_q <= issuing & (cnt == '0);
    end
  end

  // Accumulate stage: adds the fetched power of two when its bit was set.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        acc  <= '0;
        busy <= 1'b1;
      end else if (stg_v) begin
        if (bit_q) acc <= acc_sum;
        if (last_q) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end

  assign bcd_out = {{(ACC_W-BCD_W){1'b0}}, acc};

  a_r5_digits_valid: assert property (@(posedge clk) disable iff (rst)
    digits_ok(128'(bcd_out), ACC_W / 4));

  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && bcd_out == '0));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(bcd_out));

  a_r4_clear_bit_adds_nothing: assert property (@(posedge clk) disable iff (rst)
    (stg_v && !bit_q) |=> $stable(acc));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(src));

endmodule

// File: tb/sim_bcd_table_conv.sv
module sim_bcd_table_conv;
  import bcd_conv_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic        s16, s32;
  logic [15:0] d16;
  logic [31:0] d32;
  logic        b16, b32, dn16, dn32;
  logic [31:0] o16;
  logic [63:0] o32;

  int nvec = 0;
  int nbad = 0;

  bcd_table_conv #(.DATA_W(16)) u0 (
    .clk(clk), .rst(rst), .start(s16), .din(d16),
    .busy(b16), .done(dn16), .bcd_out(o16)
  );

  bcd_table_conv #(.DATA_W(32)) u1 (
    .clk(clk), .rst(rst), .start(s32), .din(d32),
    .busy(b32), .done(dn32), .bcd_out(o32)
  );

  function automatic logic [63:0] ref_bcd(input longint unsigned v);
    logic [63:0] r;
    longint unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < 16; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One conversion on either build; poke injects a start mid-run (R7).
  task automatic run(input bit wide, input longint unsigned v, input bit poke,
                     input string req);
    int          edges;
    int          want;
    logic [63:0] exp;
    logic [63:0] got;
    want = wide ? 34 : 18;
    exp  = ref_bcd(v);
    @(negedge clk);
    if (wide) begin d32 = 32'(v); s32 = 1'b1; end
    else      begin d16 = 16'(v); s16 = 1'b1; end
    @(negedge clk);
    s16 = 1'b0; s32 = 1'b0;
    edges = 1;
    got = wide ? o32 : {32'd0, o16};
    chk((wide ? b32 : b16) == 1'b1 && got == '0, "R2", got, 64'd0);
    while (!(wide ? dn32 : dn16) && edges < 200) begin
      if (poke && edges == 3) begin
        if (wide) begin d32 = ~32'(v); s32 = 1'b1; end
        else      begin d16 = ~16'(v); s16 = 1'b1; end
      end
      @(negedge clk);
      s16 = 1'b0; s32 = 1'b0;
      edges++;
    end
    got = wide ? o32 : {32'd0, o16};
    chk(edges == want, poke ? "R7 R3" : "R3", 64'(edges), 64'(want));
    chk(got == exp, req, got, exp);
    chk(digits_ok({64'd0, got}, 16), "R5", got, exp);
    chk((wide ? b32 : b16) == 1'b0, "R3", 64'(wide ? b32 : b16), 64'd0);
    @(negedge clk);
    chk((wide ? dn32 : dn16) == 1'b0, "R3", 64'(wide ? dn32 : dn16), 64'd0);
    @(negedge clk);
    got = wide ? o32 : {32'd0, o16};
    chk(got == exp, "R6", got, exp);
  endtask

  initial begin
    #(4 * 190000);
    nbad++;
    $display("FAIL R3 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    longint unsigned seed;
    rst = 1'b1; s16 = 1'b0; s32 = 1'b0; d16 = '0; d32 = '0;
    repeat (3) @(negedge clk);
    chk(b16 == 0 && dn16 == 0 && o16 == 0, "R1", {32'd0, o16}, 64'd0);
    chk(b32 == 0 && dn32 == 0 && o32 == 0, "R1", o32, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(b16 == 0 && dn16 == 0 && o16 == 0, "R1", {32'd0, o16}, 64'd0);
    chk(b32 == 0 && dn32 == 0 && o32 == 0, "R1", o32, 64'd0);

    run(1'b0, 0, 1'b0, "R8 zero16");
    run(1'b0, 65535, 1'b0, "R8 ones16");
    run(1'b1, 0, 1'b0, "R8 zero32");
    run(1'b1, 64'hFFFF_FFFF, 1'b0, "R8 ones32");
    chk(o32 == 64'h4294967295, "R8", o32, 64'h4294967295);

    for (int v = 1; v < 1024; v++) run(1'b0, longint'(v), 1'b0, "R4");
    for (int v = 1024; v < 65536; v += 37) run(1'b0, longint'(v), 1'b0, "R4");
    for (int v = 1; v < 65536; v = v * 2) run(1'b0, longint'(v), 1'b0, "R4");

    seed = 64'd12345;
    for (int i = 0; i < 250; i++) begin
      seed = (seed * 64'd6364136223846793005 + 64'd1442695040888963407);
      run(1'b1, seed >> 32, 1'b0, "R4");
    end
    for (int i = 0; i < 32; i++) run(1'b1, 64'd1 << i, 1'b0, "R4");

    run(1'b0, 12345, 1'b1, "R7");
    run(1'b0, 40000, 1'b1, "R7");
    run(1'b1, 64'd3000000001, 1'b1, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule